// File: doc/BRIEF.md
# UART receiver with idle-line wakeup

This block turns an asynchronous serial line into 8-bit or 9-bit characters. The line is sampled on a tick that runs at sixteen times the bit rate. Each bit is settled by a two-of-three vote taken around the middle of the bit. When parity is enabled, the top bit of each character is checked as a parity bit. A stop bit that reads low is flagged as a framing error, but the character is still delivered.

The receiver also watches for an idle line. An idle line is a run of ten bit times of high level, or eleven in 9-bit mode. The run can be counted from the end of the start bit or only from the end of the stop bit, whichever the control selects.

A standby request puts the receiver to sleep. In standby, characters are dropped without touching any flag. One of two wakeup methods ends standby: an idle line, or a character whose top bit is 1 (that character is then kept). A single interrupt request merges data-ready and idle, each behind its own enable.

Top module: `uart_rx_wake`

## Requirements
- R1: After reset, `rx_data` is 0 and `data_ready`, `idle_flag`, `parity_err`, `frame_err`, `standby` and `irq` are all 0.
- R2: In 8-bit mode (`nine_bit`=0), a frame is one low start bit, eight data bits sent least significant first, and one stop bit. The character appears on `rx_data[7:0]` with `rx_data[8]`=0, and `data_ready` is set by the end of the stop bit.
- R3: In 9-bit mode (`nine_bit`=1), nine data bits are received least significant first and appear on `rx_data[8:0]`.
- R4: Each bit is decided by a majority of samples 7, 8 and 9 of its sixteen. A low pulse that is over before the middle of a start bit is rejected and produces no character.
- R5: When `par_en`=1, the top data bit is the parity bit and stays in `rx_data`. With `par_odd`=0 (even) or `par_odd`=1 (odd), `parity_err` is set when the count of 1s over all data bits does not match that parity. When `par_en`=0, `parity_err` stays 0.
- R6: A stop bit read as 0 sets `frame_err`. The character is still delivered and `data_ready` is still set.
- R7: The idle threshold is 10 bit times of high line (160 samples) in 8-bit mode and 11 (176 samples) in 9-bit mode. With `idle_after_stop`=0, counting starts after the start bit, so trailing 1 data bits and the stop bit count toward it.
- R8: With `idle_after_stop`=1, counting starts only after the stop bit ends, so no part of a character counts toward the threshold.
- R9: `idle_flag` is set at most once per idle period. It is set only if a character was accepted since it was last set. No idle flag follows reset alone.
- R10: A one-cycle pulse on `clr_flags` clears `data_ready`, `idle_flag`, `parity_err` and `frame_err`.
- R11: A pulse on `standby_req` sets `standby`. In standby, characters are discarded and set no flag. With `wake_addr`=0, an idle line clears `standby` without setting `idle_flag`.
- R12: With `wake_addr`=1, a character whose top bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is 0 is discarded in standby. One whose top bit is 1 clears `standby` and is received normally. An idle line does not wake the receiver in this mode.
- R13: `irq` is high exactly when (`data_ready` and `data_irq_en`) or (`idle_flag` and `idle_irq_en`).
- R14: With `rx_en`=0, no character is received and no idle flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input, idles high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| idle_after_stop | input | 1 | 1 counts idle only after the stop bit |
| wake_addr | input | 1 | 0 idle-line wakeup, 1 address-mark wakeup |
| standby_req | input | 1 | Pulse that enters standby |
| data_irq_en | input | 1 | Interrupt enable for data-ready |
| idle_irq_en | input | 1 | Interrupt enable for idle |
| clr_flags | input | 1 | Pulse that clears the four status flags |
| rx_data | output | 9 | Last accepted character |
| data_ready | output | 1 | A character has been accepted |
| idle_flag | output | 1 | Idle line seen after a character |
| parity_err | output | 1 | Parity mismatch on the last character |
| frame_err | output | 1 | Low stop bit on the last character |
| standby | output | 1 | Receiver is in standby |
| irq | output | 1 | Merged interrupt request |

## Verification
The bench sends all-ones characters and then samples the idle flag between the two possible thresholds. A counter that started at the wrong point, or used the 8-bit limit in 9-bit mode, would raise the flag too early or too late. Short low glitches and a low stop bit are used to catch a start check that does not vote at mid-bit, and a framing error that drops the data. In standby, address-marked and plain characters are mixed with long idle gaps. This exposes a receiver that leaks flags while asleep, wakes on the wrong event, or raises a second idle flag without a new character.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
  // widest character, parity bit included
  localparam int MAX_BITS = 9;
  localparam int IDX_W    = $clog2(MAX_BITS);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/rx_sampler.sv
`timescale 1ns/1ps
module rx_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic os_tick,
  output logic smp_stb,
  output logic smp_cur,
  output logic smp_vote
);
  import uart_rx_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [2:0]             hist_q, hist_d;
  logic                   stb_q, stb_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], rx_line};
    hist_d = hist_q;
    if (os_tick) begin
      hist_d = {hist_q[1:0], sync_q[SYNC_STAGES-1]};
    end
    stb_d = os_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      stb_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
      stb_q  <= stb_d;
    end
  end

  assign smp_stb  = stb_q;
  assign smp_cur  = hist_q[0];
  assign smp_vote = maj3(hist_q);
endmodule

// File: rtl/rx_frame.sv
`timescale 1ns/1ps
module rx_frame #(
  parameter int OS_RATE = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rx_en,
  input  logic                              nine_bit,
  input  logic                              smp_stb,
  input  logic                              smp_cur,
  input  logic                              smp_vote,
  output logic                              in_idle,
  output logic                              char_stb,
  output logic [uart_rx_pkg::MAX_BITS-1:0]  char_data,
  output logic                              char_stop
);
  import uart_rx_pkg::*;

  localparam int             CW      = $clog2(OS_RATE);
  localparam logic [CW-1:0]  VOTE_AT = CW'(OS_RATE / 2 + 1);
  localparam logic [CW-1:0]  LAST    = CW'(OS_RATE - 1);

  rx_state_e             state_q, state_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [MAX_BITS-1:0]   sr_q, sr_d;
  logic                  cstb_q, cstb_d;
  logic [MAX_BITS-1:0]   cdata_q, cdata_d;
  logic                  cstop_q, cstop_d;
  logic [IDX_W-1:0]      last_idx;

  assign last_idx = nine_bit ? IDX_W'(MAX_BITS - 1) : IDX_W'(MAX_BITS - 2);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sr_d    = sr_q;
    cstb_d  = 1'b0;
    cdata_d = cdata_q;
    cstop_d = cstop_q;
    if (!rx_en) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (smp_stb) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      case (state_q)
        ST_IDLE: begin
          cnt_d = '0;
          if (!smp_cur) begin
            state_d = ST_START;
            cnt_d   = CW'(1);
          end
        end
        ST_START: begin
          if (cnt_q == VOTE_AT && smp_vote) begin
            state_d = ST_IDLE;   // line back high at mid-bit: false start
            cnt_d   = '0;
          end else if (cnt_q == LAST) begin
            state_d = ST_DATA;
            idx_d   = '0;
            sr_d    = '0;
          end
        end
        ST_DATA: begin
          if (cnt_q == VOTE_AT) begin
            sr_d[idx_q] = smp_vote;
          end
          if (cnt_q == LAST) begin
            if (idx_q == last_idx) begin
              state_d = ST_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (cnt_q == VOTE_AT) begin
            cstb_d  = 1'b1;
            cdata_d = nine_bit ? sr_q : {1'b0, sr_q[MAX_BITS-2:0]};
            cstop_d = smp_vote;
          end else if (cnt_q > VOTE_AT && !smp_cur) begin
            state_d = ST_START;  // early start edge in second half of stop
            cnt_d   = CW'(1);
          end else if (cnt_q == LAST) begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sr_q    <= '0;
      cstb_q  <= 1'b0;
      cdata_q <= '0;
      cstop_q <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sr_q    <= sr_d;
      cstb_q  <= cstb_d;
      cdata_q <= cdata_d;
      cstop_q <= cstop_d;
    end
  end

  assign in_idle   = (state_q == ST_IDLE);
  assign char_stb  = cstb_q;
  assign char_data = cdata_q;
  assign char_stop = cstop_q;

  // R2: a character is only handed out from the stop-bit phase
  a_r2_char_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    cstb_q |-> $past(state_q) == ST_STOP);
endmodule

// File: rtl/rx_idle_det.sv
`timescale 1ns/1ps
module rx_idle_det #(
  parameter int OS_RATE     = 16,
  parameter int IDLE_BITS_8 = 10,
  parameter int IDLE_BITS_9 = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic nine_bit,
  input  logic after_stop,
  input  logic in_idle,
  input  logic smp_stb,
  input  logic smp_cur,
  output logic idle_hit
);
  localparam int TMAX = IDLE_BITS_9 * OS_RATE;
  localparam int IW   = $clog2(TMAX + 1);

  logic [IW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] thr;
  logic          hit_q, hit_d;

  assign thr = nine_bit ? IW'(IDLE_BITS_9 * OS_RATE) : IW'(IDLE_BITS_8 * OS_RATE);

  always_comb begin
    cnt_d = cnt_q;
    hit_d = 1'b0;
    if (!rx_en) begin
      cnt_d = '0;
    end else if (smp_stb) begin
      if (!smp_cur || (after_stop && !in_idle)) begin
        cnt_d = '0;
      end else if (cnt_q < thr) begin
        cnt_d = cnt_q + 1'b1;
        hit_d = (cnt_q == thr - 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hit_q <= hit_d;
    end
  end

  assign idle_hit = hit_q;

  // R9: one idle period yields one detection pulse
  a_r9_hit_once: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |=> !hit_q);
endmodule

// File: rtl/uart_rx_wake.sv
`timescale 1ns/1ps
module uart_rx_wake #(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_BITS_8 = 10,
  parameter int IDLE_BITS_9 = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       os_tick,
  input  logic       rx_en,
  input  logic       nine_bit,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       idle_after_stop,
  input  logic       wake_addr,
  input  logic       standby_req,
  input  logic       data_irq_en,
  input  logic       idle_irq_en,
  input  logic       clr_flags,
  output logic [8:0] rx_data,
  output logic       data_ready,
  output logic       idle_flag,
  output logic       parity_err,
  output logic       frame_err,
  output logic       standby,
  output logic       irq
);
  import uart_rx_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q, rst_li;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_li = rst_sync_q;

  logic                smp_stb, smp_cur, smp_vote;
  logic                in_idle, char_stb, char_stop, idle_hit;
  logic [MAX_BITS-1:0] char_data;

  rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk      (clk),
    .rst_n    (rst_li),
    .rx_line  (rx_line),
    .os_tick  (os_tick),
    .smp_stb  (smp_stb),
    .smp_cur  (smp_cur),
    .smp_vote (smp_vote)
  );

  rx_frame #(.OS_RATE(OS_RATE)) u_frm (
    .clk       (clk),
    .rst_n     (rst_li),
    .rx_en     (rx_en),
    .nine_bit  (nine_bit),
    .smp_stb   (smp_stb),
    .smp_cur   (smp_cur),
    .smp_vote  (smp_vote),
    .in_idle   (in_idle),
    .char_stb  (char_stb),
    .char_data (char_data),
    .char_stop (char_stop)
  );

  rx_idle_det #(
    .OS_RATE     (OS_RATE),
    .IDLE_BITS_8 (IDLE_BITS_8),
    .IDLE_BITS_9 (IDLE_BITS_9)
  ) u_idl (
    .clk        (clk),
    .rst_n      (rst_li),
    .rx_en      (rx_en),
    .nine_bit   (nine_bit),
    .after_stop (idle_after_stop),
    .in_idle    (in_idle),
    .smp_stb    (smp_stb),
    .smp_cur    (smp_cur),
    .idle_hit   (idle_hit)
  );

  logic [8:0] data_q, data_d;
  logic       dr_q, dr_d, idle_q, idle_d, pe_q, pe_d, fe_q, fe_d;
  logic       armed_q, armed_d, stby_q, stby_d;
  logic       msb, par_bad, accept, wake, idle_set;

  always_comb begin
    msb      = nine_bit ? char_data[8] : char_data[7];
    par_bad  = par_en && ((^char_data) != par_odd);
    accept   = char_stb && (!stby_q || (wake_addr && msb));
    wake     = stby_q && ((wake_addr && char_stb && msb) || (!wake_addr && idle_hit));
    idle_set = idle_hit && armed_q && !stby_q;

    data_d  = data_q;
    dr_d    = dr_q;
    idle_d  = idle_q;
    pe_d    = pe_q;
    fe_d    = fe_q;
    armed_d = armed_q;
    stby_d  = stby_q;

    if (clr_flags) begin
      dr_d   = 1'b0;
      idle_d = 1'b0;
      pe_d   = 1'b0;
      fe_d   = 1'b0;
    end
    if (accept) begin
      data_d  = char_data;
      dr_d    = 1'b1;
      pe_d    = par_bad;
      fe_d    = !char_stop;
      armed_d = 1'b1;
    end
    if (idle_set) begin
      idle_d  = 1'b1;
      armed_d = 1'b0;
    end
    if (standby_req) begin
      stby_d = 1'b1;
    end else if (wake) begin
      stby_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_li) begin
    if (!rst_li) begin
      data_q  <= '0;
      dr_q    <= 1'b0;
      idle_q  <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      armed_q <= 1'b0;
      stby_q  <= 1'b0;
    end else begin
      data_q  <= data_d;
      dr_q    <= dr_d;
      idle_q  <= idle_d;
      pe_q    <= pe_d;
      fe_q    <= fe_d;
      armed_q <= armed_d;
      stby_q  <= stby_d;
    end
  end

  assign rx_data    = data_q;
  assign data_ready = dr_q;
  assign idle_flag  = idle_q;
  assign parity_err = pe_q;
  assign frame_err  = fe_q;
  assign standby    = stby_q;
  assign irq        = (dr_q & data_irq_en) | (idle_q & idle_irq_en);

  // R9: the idle flag only rises after a character has armed it
  a_r9_idle_needs_char: assert property (@(posedge clk) disable iff (!rst_li)
    $rose(idle_q) |-> $past(armed_q));

  // R11: idle-wakeup standby never lets a character through
  a_r11_standby_discards: assert property (@(posedge clk) disable iff (!rst_li)
    (stby_q && !wake_addr) |=> !$rose(dr_q));

  // R12: leaving address-mark standby always comes with a delivered character
  a_r12_addr_wake_delivers: assert property (@(posedge clk) disable iff (!rst_li)
    (stby_q && wake_addr && !standby_req) |=> (stby_q || dr_q));

  // R11: no idle flag can rise while asleep
  a_r11_no_idle_in_standby: assert property (@(posedge clk) disable iff (!rst_li)
    stby_q |=> !$rose(idle_q));
endmodule

// File: tb/uart_rx_wake_tb.sv
`timescale 1ns/1ps
module uart_rx_wake_tb;
  localparam int TICK_DIV = 4;
  localparam int OSR      = 16;
  localparam int BIT_CLK  = TICK_DIV * OSR;

  logic       clk, rst_n, rx_line, os_tick;
  logic       rx_en, nine_bit, par_en, par_odd, idle_after_stop, wake_addr;
  logic       standby_req, data_irq_en, idle_irq_en, clr_flags;
  logic [8:0] rx_data;
  logic       data_ready, idle_flag, parity_err, frame_err, standby, irq;

  int checks = 0;
  int errors = 0;

  uart_rx_wake u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .rx_en(rx_en), .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
    .idle_after_stop(idle_after_stop), .wake_addr(wake_addr),
    .standby_req(standby_req), .data_irq_en(data_irq_en),
    .idle_irq_en(idle_irq_en), .clr_flags(clr_flags),
    .rx_data(rx_data), .data_ready(data_ready), .idle_flag(idle_flag),
    .parity_err(parity_err), .frame_err(frame_err), .standby(standby), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  initial begin
    os_tick = 1'b0;
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * BIT_CLK) @(negedge clk);
  endtask

  task automatic send_char(input logic [8:0] d, input logic nine, input logic stop_v);
    int nb;
    nb = nine ? 9 : 8;
    rx_line = 1'b0;
    wait_bits(1);
    for (int i = 0; i < nb; i++) begin
      rx_line = d[i];
      wait_bits(1);
    end
    rx_line = stop_v;
    wait_bits(1);
    rx_line = 1'b1;
  endtask

  task automatic pulse_clr();
    clr_flags = 1'b1;
    @(negedge clk);
    clr_flags = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_standby();
    standby_req = 1'b1;
    @(negedge clk);
    standby_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    wait_bits(13);
    pulse_clr();
  endtask

  task automatic t_reset();
    check("R1", "data_ready", data_ready, 0);
    check("R1", "idle_flag", idle_flag, 0);
    check("R1", "parity_err", parity_err, 0);
    check("R1", "frame_err", frame_err, 0);
    check("R1", "standby", standby, 0);
    check("R1", "irq", irq, 0);
    check("R1", "rx_data", rx_data, 0);
    wait_bits(12);
    check("R9", "no idle before any character", idle_flag, 0);
  endtask

  task automatic t_basic8();
    send_char(9'h0A5, 1'b0, 1'b1);
    check("R2", "data_ready", data_ready, 1);
    check("R2", "rx_data 8-bit", rx_data, 9'h0A5);
    check("R2", "frame_err", frame_err, 0);
    pulse_clr();
    check("R10", "data_ready after clear", data_ready, 0);
    settle();
  endtask

  task automatic t_nine();
    nine_bit = 1'b1;
    send_char(9'h1C3, 1'b1, 1'b1);
    check("R3", "rx_data 9-bit", rx_data, 9'h1C3);
    check("R3", "data_ready", data_ready, 1);
    settle();
    nine_bit = 1'b0;
  endtask

  task automatic t_glitch();
    rx_line = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    rx_line = 1'b1;
    wait_bits(12);
    check("R4", "short low pulse ignored", data_ready, 0);
    send_char(9'h03C, 1'b0, 1'b1);
    check("R4", "char after glitch", rx_data, 9'h03C);
    settle();
  endtask

  task automatic t_parity();
    par_en = 1'b1;
    par_odd = 1'b0;
    send_char(9'h041, 1'b0, 1'b1);
    check("R5", "even ok", parity_err, 0);
    pulse_clr();
    send_char(9'h0C1, 1'b0, 1'b1);
    check("R5", "even bad", parity_err, 1);
    check("R5", "parity bit kept", rx_data, 9'h0C1);
    check("R5", "data_ready with bad parity", data_ready, 1);
    pulse_clr();
    check("R10", "parity_err cleared", parity_err, 0);
    par_odd = 1'b1;
    send_char(9'h0C1, 1'b0, 1'b1);
    check("R5", "odd ok", parity_err, 0);
    pulse_clr();
    send_char(9'h041, 1'b0, 1'b1);
    check("R5", "odd bad", parity_err, 1);
    pulse_clr();
    nine_bit = 1'b1;
    par_odd = 1'b0;
    send_char(9'h101, 1'b1, 1'b1);
    check("R5", "9-bit even ok", parity_err, 0);
    pulse_clr();
    send_char(9'h001, 1'b1, 1'b1);
    check("R5", "9-bit even bad", parity_err, 1);
    pulse_clr();
    nine_bit = 1'b0;
    par_en = 1'b0;
    send_char(9'h0C1, 1'b0, 1'b1);
    check("R5", "no check when disabled", parity_err, 0);
    settle();
  endtask

  task automatic t_frame();
    send_char(9'h05A, 1'b0, 1'b0);
    check("R6", "frame_err", frame_err, 1);
    check("R6", "data delivered", rx_data, 9'h05A);
    check("R6", "data_ready", data_ready, 1);
    settle();
    check("R10", "frame_err cleared", frame_err, 0);
  endtask

  task automatic t_idle0();
    idle_after_stop = 1'b0;
    send_char(9'h0FF, 1'b0, 1'b1);
    check("R7", "idle not yet", idle_flag, 0);
    wait_bits(3);
    check("R7", "idle counted from start bit", idle_flag, 1);
    pulse_clr();
    check("R10", "idle cleared", idle_flag, 0);
    wait_bits(12);
    check("R9", "no second idle without char", idle_flag, 0);
    nine_bit = 1'b1;
    send_char(9'h1FF, 1'b1, 1'b1);
    repeat (BIT_CLK / 2) @(negedge clk);
    check("R7", "9-bit threshold is 11", idle_flag, 0);
    wait_bits(2);
    check("R7", "9-bit idle reached", idle_flag, 1);
    settle();
    nine_bit = 1'b0;
  endtask

  task automatic t_idle1();
    idle_after_stop = 1'b1;
    send_char(9'h0FF, 1'b0, 1'b1);
    wait_bits(9);
    check("R8", "idle waits for 10 bits after stop", idle_flag, 0);
    wait_bits(2);
    check("R8", "idle after stop", idle_flag, 1);
    settle();
    idle_after_stop = 1'b0;
  endtask

  task automatic t_standby_idle();
    wake_addr = 1'b0;
    pulse_standby();
    check("R11", "standby set", standby, 1);
    send_char(9'h033, 1'b0, 1'b1);
    check("R11", "char discarded", data_ready, 0);
    check("R11", "still asleep", standby, 1);
    wait_bits(12);
    check("R11", "idle wakes", standby, 0);
    check("R11", "no idle flag on wake", idle_flag, 0);
    settle();
  endtask

  task automatic t_addr();
    nine_bit = 1'b1;
    wake_addr = 1'b1;
    pulse_standby();
    send_char(9'h055, 1'b1, 1'b1);
    check("R12", "plain char discarded", data_ready, 0);
    check("R12", "plain char no frame flag", frame_err, 0);
    wait_bits(12);
    check("R12", "idle does not wake", standby, 1);
    check("R12", "no idle flag", idle_flag, 0);
    send_char(9'h1AA, 1'b1, 1'b1);
    check("R12", "marked char wakes", standby, 0);
    check("R12", "marked char received", rx_data, 9'h1AA);
    check("R12", "data_ready", data_ready, 1);
    settle();
    nine_bit = 1'b0;
    wake_addr = 1'b0;
  endtask

  task automatic t_irq();
    data_irq_en = 1'b0;
    idle_irq_en = 1'b0;
    send_char(9'h011, 1'b0, 1'b1);
    check("R13", "data polled only", irq, 0);
    data_irq_en = 1'b1;
    @(negedge clk);
    check("R13", "data irq", irq, 1);
    data_irq_en = 1'b0;
    pulse_clr();
    idle_irq_en = 1'b1;
    wait_bits(13);
    check("R13", "idle flag", idle_flag, 1);
    check("R13", "idle irq", irq, 1);
    pulse_clr();
    check("R13", "irq gone after clear", irq, 0);
    idle_irq_en = 1'b0;
  endtask

  task automatic t_disabled();
    rx_en = 1'b0;
    send_char(9'h077, 1'b0, 1'b1);
    check("R14", "no char when disabled", data_ready, 0);
    wait_bits(12);
    check("R14", "no idle when disabled", idle_flag, 0);
    rx_en = 1'b1;
    wait_bits(1);
    send_char(9'h077, 1'b0, 1'b1);
    check("R14", "receives after enable", rx_data, 9'h077);
  endtask

  initial begin
    rst_n = 1'b0;
    rx_line = 1'b1;
    rx_en = 1'b1;
    nine_bit = 1'b0;
    par_en = 1'b0;
    par_odd = 1'b0;
    idle_after_stop = 1'b0;
    wake_addr = 1'b0;
    standby_req = 1'b0;
    data_irq_en = 1'b0;
    idle_irq_en = 1'b0;
    clr_flags = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic8();
    t_nine();
    t_glitch();
    t_parity();
    t_frame();
    t_idle0();
    t_idle1();
    t_standby_idle();
    t_addr();
    t_irq();
    t_disabled();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule